// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block moves data words from a write clock domain to an unrelated read clock domain through a storage array of 2^AW words. Pointers cross between the domains as Gray codes through two-flop synchronizers. Each side works out its fill level from its own pointer and the synchronized copy of the other side's pointer. The write side drives a full flag and an almost-full flag, both registered on the write clock. The read side drives an empty flag and an almost-empty flag, both registered on the read clock. The two thresholds are fixed at elaboration by the parameters AF_OFS and AE_OFS.

Two read modes are available. In standard mode a word is fetched only on request and appears one read clock later with a valid strobe. In fall-through mode the oldest word is loaded into the output register without a request and stays there until it is consumed. The output register then holds one word beyond the array, so the total capacity becomes 2^AW + 1 and the almost-empty thresholds move up by one word. The mode pin is sampled only while the master reset is asserted.

The single active-low master reset is asserted asynchronously. Its release is synchronized separately into each clock domain.

Top module: `dcfifo_pflag`

## Requirements
- R1: Words come out on the read side in the order they were accepted on the write side, with no loss and no duplication, under any mix of write and read activity.
- R2: `wr_full` is high exactly when the array holds 2^AW words. A write attempted while `wr_full` is high is dropped, and its word never appears on the read side.
- R3: A read request while `rd_empty` is high has no effect. In standard mode no `rd_valid` pulse follows it, and the contents of the FIFO are unchanged.
- R4: In standard mode, a read request accepted at a read clock edge (with `rd_empty` low) returns the oldest word on `rd_data`, with `rd_valid` high, right after that edge. `rd_valid` is high for that one cycle only.
- R5: In fall-through mode, the oldest word appears on `rd_data` with `rd_valid` high without any request. It stays stable until a read request consumes it, and the total capacity is 2^AW + 1 words.
- R6: `wr_afull` is high when the array holds at least 2^AW − AF_OFS words and low once it holds 2^AW − AF_OFS − 1 or fewer. It changes only on `wr_clk` edges, and a write updates it at the same edge.
- R7: In standard mode, `rd_aempty` is high at AE_OFS words or fewer and low from AE_OFS + 1 words. A read updates it at the same read clock edge.
- R8: In fall-through mode, `rd_aempty` counts the word held in the output register. It is high at AE_OFS + 1 words or fewer in total and low from AE_OFS + 2 words.
- R9: An event in the opposite domain reaches a flag within three edges of the flag's own clock, plus at most one more edge when the two clock edges fall close together.
- R10: `fwft_sel` (0 = standard, 1 = fall-through) takes effect only while `mrst_n` is low. Changing it during operation does not change the read behaviour.
- R11: While `mrst_n` is low and just after it is released, `wr_full`, `wr_afull` and `rd_valid` are low, and `rd_empty` and `rd_aempty` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| fwft_sel | input | 1 | Read mode select, sampled during reset (1 = fall-through) |
| wr_clk | input | 1 | Write domain clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | Array full, registered on wr_clk |
| wr_afull | output | 1 | Almost-full flag, registered on wr_clk |
| rd_clk | input | 1 | Read domain clock |
| rd_en | input | 1 | Read request (consume in fall-through mode) |
| rd_data | output | DW | Output word register |
| rd_valid | output | 1 | rd_data holds a valid word |
| rd_empty | output | 1 | Nothing to read, registered on rd_clk |
| rd_aempty | output | 1 | Almost-empty flag, registered on rd_clk |

## Verification
The risky overlap is a write landing in the same window as a read. The flag on each side must then combine its own pointer move with a synchronized pointer that is changing at that moment. The bench provokes this with write and read clocks of unrelated periods and random enables at rates that drive the FIFO to full and to empty many times. Every word is compared in order against a model queue. After activity stops, each flag is compared exactly against the model count. Cross-domain flag releases are timed against the allowed window of edges.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Prefix XOR from the top bit down; upper zero bits leave the result intact.
  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) begin
      b = b ^ (b >> s);
    end
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/1ps
module dcf_mem #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] arr_q [WORDS];

  always_ff @(posedge wr_clk) begin
    if (we) arr_q[waddr] <= wdata;
  end

  assign rdata = arr_q[raddr];

endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int AW     = 4,
  parameter int AF_OFS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          afull
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP    = PW'(1 << AW);
  localparam logic [PW-1:0] AF_LVL = PW'((1 << AW) - AF_OFS);

  logic [PW-1:0] wbin_q, wbin_n, wgray_q, wgray_n, rbin_s, cnt_n;
  logic          full_q, full_n, af_q, af_n;

  always_comb begin
    push    = wr_en & ~full_q;
    wbin_n  = wbin_q + PW'(push);
    wgray_n = PW'(bin2gray(32'(wbin_n)));
    rbin_s  = PW'(gray2bin(32'(rgray_s)));
    cnt_n   = wbin_n - rbin_s;
    full_n  = (cnt_n == CAP);
    af_n    = (cnt_n >= AF_LVL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      af_q    <= 1'b0;
    end else begin
      if (push) begin
        wbin_q  <= wbin_n;
        wgray_q <= wgray_n;
      end
      full_q <= full_n;
      af_q   <= af_n;
    end
  end

  assign waddr = wbin_q[AW-1:0];
  assign wgray = wgray_q;
  assign full  = full_q;
  assign afull = af_q;

  // R2
  wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && wr_en) |=> $stable(wbin_q));

  // R6
  af_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> af_q);

  // R1
  wr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (PW'(wbin_q - rbin_s) <= CAP));

endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 4,
  parameter int AE_OFS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_empty,
  output logic          rd_aempty
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP      = PW'(1 << AW);
  localparam logic [PW-1:0] AE_STD   = PW'(AE_OFS);
  localparam logic [PW-1:0] AE_FWFT  = PW'(AE_OFS + 1);

  rd_mode_e      mode_q;
  logic          cfg_win_q;
  logic [PW-1:0] rbin_q, rbin_n, rgray_q, rgray_n, wbin_s, cnt_n, tot_n;
  logic [DW-1:0] dat_q, dat_n;
  logic          vld_q, vld_n, mty_q, mty_n, ae_q, ae_n;
  logic          take, consume, fwft;

  // Mode capture window: open during reset and closes one edge after release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_win_q <= 1'b1;
    else        cfg_win_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (cfg_win_q) mode_q <= rd_mode_e'(mode_sel);
  end

  always_comb begin
    fwft    = (mode_q == RD_FWFT);
    consume = rd_en & vld_q;
    if (fwft) begin
      take  = ~mty_q & (~vld_q | consume);
      vld_n = take | (vld_q & ~consume);
    end else begin
      take  = rd_en & ~mty_q;
      vld_n = take;
    end
    rbin_n  = rbin_q + PW'(take);
    rgray_n = PW'(bin2gray(32'(rbin_n)));
    wbin_s  = PW'(gray2bin(32'(wgray_s)));
    cnt_n   = wbin_s - rbin_n;
    mty_n   = (cnt_n == '0);
    tot_n   = cnt_n + PW'(fwft & vld_n);
    ae_n    = fwft ? (tot_n <= AE_FWFT) : (tot_n <= AE_STD);
    dat_n   = take ? mem_rdata : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      dat_q   <= '0;
      vld_q   <= 1'b0;
      mty_q   <= 1'b1;
      ae_q    <= 1'b1;
    end else begin
      if (take) begin
        rbin_q  <= rbin_n;
        rgray_q <= rgray_n;
        dat_q   <= dat_n;
      end
      vld_q <= vld_n;
      mty_q <= mty_n;
      ae_q  <= ae_n;
    end
  end

  assign raddr     = rbin_q[AW-1:0];
  assign rgray     = rgray_q;
  assign rd_data   = dat_q;
  assign rd_valid  = vld_q;
  assign rd_empty  = fwft ? ~vld_q : mty_q;
  assign rd_aempty = ae_q;

  // R3
  rd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RD_STD && rd_en && mty_q) |=> (!vld_q && $stable(rbin_q)));

  // R5
  fwft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RD_FWFT && vld_q && !rd_en) |=> (vld_q && $stable(dat_q)));

  // R7
  std_ae_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RD_STD && mty_q) |-> ae_q);

  // R1
  rd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (PW'(wbin_s - rbin_q) <= CAP));

endmodule

// File: rtl/dcfifo_pflag.sv
`timescale 1ns/1ps
module dcfifo_pflag #(
  parameter int DW     = 16,
  parameter int AW     = 4,
  parameter int AF_OFS = 3,
  parameter int AE_OFS = 2,
  parameter int SYNC_N = 2
) (
  input  logic          mrst_n,
  input  logic          fwft_sel,
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  output logic          wr_afull,
  input  logic          rd_clk,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_empty,
  output logic          rd_aempty
);

  localparam int PW = AW + 1;

  logic          wrst_n, rrst_n, push;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] mem_rdata;

  dcf_sync #(.W(1), .STAGES(SYNC_N)) wr_rst_sync (
    .clk(wr_clk), .rst_n(mrst_n), .d(1'b1), .q(wrst_n));

  dcf_sync #(.W(1), .STAGES(SYNC_N)) rd_rst_sync (
    .clk(rd_clk), .rst_n(mrst_n), .d(1'b1), .q(rrst_n));

  dcf_sync #(.W(PW), .STAGES(SYNC_N)) r2w_sync (
    .clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));

  dcf_sync #(.W(PW), .STAGES(SYNC_N)) w2r_sync (
    .clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  dcf_mem #(.DW(DW), .AW(AW)) mem_i (
    .wr_clk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata));

  dcf_wr_side #(.AW(AW), .AF_OFS(AF_OFS)) wr_i (
    .clk(wr_clk), .rst_n(wrst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .push(push), .waddr(waddr), .wgray(wgray), .full(wr_full), .afull(wr_afull));

  dcf_rd_side #(.DW(DW), .AW(AW), .AE_OFS(AE_OFS)) rd_i (
    .clk(rd_clk), .rst_n(rrst_n), .mode_sel(fwft_sel), .rd_en(rd_en),
    .wgray_s(wgray_s), .mem_rdata(mem_rdata), .raddr(raddr), .rgray(rgray),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_empty(rd_empty), .rd_aempty(rd_aempty));

endmodule

// File: tb/dcfifo_pflag_tb_top.sv
`timescale 1ns/1ps
module dcfifo_pflag_tb_top;

  localparam int DW    = 16;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int AFO   = 3;
  localparam int AEO   = 2;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  always #10 wr_clk = ~wr_clk;
  always #13 rd_clk = ~rd_clk;

  logic          mrst_n, fwft_sel, wr_en, rd_en;
  logic [DW-1:0] wr_data, rd_data;
  logic          wr_full, wr_afull, rd_valid, rd_empty, rd_aempty;

  dcfifo_pflag #(.DW(DW), .AW(AW), .AF_OFS(AFO), .AE_OFS(AEO)) dut_i (
    .mrst_n(mrst_n), .fwft_sel(fwft_sel),
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full), .wr_afull(wr_afull),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_empty(rd_empty), .rd_aempty(rd_aempty));

  logic [DW-1:0] mdl_q[$];
  logic [DW-1:0] pend_d;
  bit            pend_v, fw, done;
  int            n_vec, n_bad;

  task automatic check(input bit ok, input string req, input int unsigned act, input int unsigned exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input bit mode);
    mrst_n = 1'b0; fwft_sel = mode; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    fw = mode; pend_v = 1'b0; mdl_q.delete();
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
    mrst_n = 1'b1;
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
  endtask

  task automatic chk_reset();
    check(wr_full === 1'b0,   "R11", wr_full, 0);
    check(wr_afull === 1'b0,  "R11", wr_afull, 0);
    check(rd_valid === 1'b0,  "R11", rd_valid, 0);
    check(rd_empty === 1'b1,  "R11", rd_empty, 1);
    check(rd_aempty === 1'b1, "R11", rd_aempty, 1);
  endtask

  task automatic wr_one(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = d;
    if (!wr_full) mdl_q.push_back(d);
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_step(input bit do_rd);
    @(negedge rd_clk);
    if (!fw) begin
      if (pend_v) check(rd_valid === 1'b1 && rd_data === pend_d, "R4", rd_data, pend_d);
      else        check(rd_valid === 1'b0, "R3", rd_valid, 0);
      pend_v = do_rd && !rd_empty;
      if (pend_v) pend_d = mdl_q.pop_front();
    end else if (rd_valid) begin
      if (mdl_q.size() > 0) begin
        check(rd_data === mdl_q[0], "R1", rd_data, mdl_q[0]);
        if (do_rd) void'(mdl_q.pop_front());
      end else check(1'b0, "R1", rd_data, 0);
    end
    rd_en = do_rd;
  endtask

  task automatic settle();
    rd_step(1'b0);
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic chk_flags();
    int tot, memw;
    tot  = mdl_q.size();
    memw = (fw && tot > 0) ? tot - 1 : tot;
    check(wr_full === (memw == DEPTH),      "R2", wr_full, memw == DEPTH);
    check(wr_afull === (memw >= DEPTH-AFO), "R6", wr_afull, memw >= DEPTH-AFO);
    check(rd_empty === (tot == 0),          "R3", rd_empty, tot == 0);
    if (fw) check(rd_aempty === (tot <= AEO+1), "R8", rd_aempty, tot <= AEO+1);
    else    check(rd_aempty === (tot <= AEO),   "R7", rd_aempty, tot <= AEO);
  endtask

  task automatic rd_pop_chk();
    rd_step(1'b1);
    rd_step(1'b0);
    if (fw) check(rd_aempty === (mdl_q.size() <= AEO+1), "R8", rd_aempty, mdl_q.size() <= AEO+1);
    else    check(rd_aempty === (mdl_q.size() <= AEO),   "R7", rd_aempty, mdl_q.size() <= AEO);
    check(rd_empty === (mdl_q.size() == 0), "R3", rd_empty, mdl_q.size() == 0);
  endtask

  task automatic wr_random(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      if ($urandom_range(99) < pct) begin
        wr_en = 1'b1; wr_data = DW'($urandom);
        if (!wr_full) mdl_q.push_back(wr_data);
      end else wr_en = 1'b0;
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_random(input int n, input int pct);
    for (int i = 0; i < n; i++) rd_step($urandom_range(99) < pct);
  endtask

  task automatic drain();
    for (int i = 0; i < 4*DEPTH + 40; i++) rd_step(1'b1);
    rd_step(1'b0);
    check(mdl_q.size() == 0, "R1", mdl_q.size(), 0);
  endtask

  task automatic random_phase(input int pw, input int pr);
    fork
      wr_random(300, pw);
      rd_random(300, pr);
    join
    drain();
    settle();
    chk_flags();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    n_bad++;
    $display("FAIL R1: watchdog expired, actual 0 expected 1");
    finish_run();
  end

  initial begin
    int cyc;
    void'($urandom(32'h5EED_1234));
    n_vec = 0; n_bad = 0; done = 1'b0;

    // ---- standard mode ----
    do_reset(1'b0);
    chk_reset();

    // R10: mode pin change during operation is ignored
    fwft_sel = 1'b1;
    wr_one(16'hA5A5);
    settle();
    check(rd_valid === 1'b0 && rd_empty === 1'b0, "R10", {rd_valid, rd_empty}, 2'b00);
    rd_step(1'b1);
    rd_step(1'b0);
    fwft_sel = 1'b0;

    // R2 / R6: fill with reader idle, two extra writes must be dropped
    for (int k = 0; k < DEPTH + 2; k++) begin
      wr_one(DW'(16'h1000 + k));
      check(wr_full === (mdl_q.size() == DEPTH), "R2", wr_full, mdl_q.size() == DEPTH);
      check(wr_afull === (mdl_q.size() >= DEPTH-AFO), "R6", wr_afull, mdl_q.size() >= DEPTH-AFO);
    end
    check(mdl_q.size() == DEPTH, "R2", mdl_q.size(), DEPTH);

    // R7: reading down, own-domain flag exact
    while (mdl_q.size() > DEPTH-AFO-1) rd_pop_chk();
    // R9: almost-full release after reads
    cyc = 0;
    while (wr_afull === 1'b1 && cyc < 12) begin @(negedge wr_clk); cyc++; end
    check(wr_afull === 1'b0 && cyc <= 5, "R9", cyc, 5);
    while (mdl_q.size() > 0) rd_pop_chk();

    // R3: read while empty
    rd_step(1'b1);
    rd_step(1'b0);
    check(rd_empty === 1'b1 && mdl_q.size() == 0, "R3", rd_empty, 1);

    // R9: almost-empty release after writes
    for (int k = 0; k <= AEO; k++) wr_one(DW'(16'h2000 + k));
    check(rd_aempty === 1'b1, "R9", rd_aempty, 1);
    cyc = 0;
    while (rd_aempty === 1'b1 && cyc < 12) begin @(negedge rd_clk); cyc++; end
    check(rd_aempty === 1'b0 && cyc <= 5, "R9", cyc, 5);
    drain();

    // R1: random traffic
    random_phase(75, 35);
    random_phase(35, 85);

    // ---- fall-through mode ----
    do_reset(1'b1);
    chk_reset();
    wr_one(16'hBEEF);
    settle();
    check(rd_valid === 1'b1 && rd_data === 16'hBEEF, "R5", rd_data, 16'hBEEF);
    repeat (3) @(negedge rd_clk);
    check(rd_valid === 1'b1 && rd_data === 16'hBEEF, "R5", rd_data, 16'hBEEF);

    for (int k = 0; k < DEPTH + 1; k++) wr_one(DW'(16'h3000 + k));
    check(mdl_q.size() == DEPTH + 1, "R5", mdl_q.size(), DEPTH + 1);
    settle();
    chk_flags();

    // R8: reading down with the output word counted
    while (mdl_q.size() > 0) rd_pop_chk();
    rd_step(1'b1);
    rd_step(1'b0);
    check(rd_valid === 1'b0 && rd_empty === 1'b1, "R3", rd_valid, 0);

    random_phase(75, 35);
    random_phase(35, 85);

    finish_run();
  end

endmodule